// File: doc/BRIEF.md
# Multi-mode position counter

This block keeps a signed position by counting single-cycle pulses up or down. One preset register does several jobs. It can be copied into the count. It is the upper bound in clamped mode and the wrap point in modulo mode. It is also the target value for an equality compare. The count can run in one of four limit behaviours:

- **Free wrapping**: the count wraps around at both ends.
- **One-shot**: counting stops at the first wrap.
- **Clamped**: the count holds between zero and the preset.
- **Modulo**: the count divides the pulse rate by preset plus one.

The count is cleared, loaded or copied into a snapshot register by commands. An external index event can also do this. Event status bits are held until software clears them. A negative-sign bit is tracked apart from the count value. Two flag pins report the events, the sign or the direction.

Top module: `poscnt_top`

## Requirements
- R1: After reset these are all zero: the count, the snapshot, the preset, the sticky status bits, the sign and the one-shot halt. With all event enables zero, `flag_a_n` is high.
- R2: With `mode`=00 (free wrapping), an accepted up pulse at all-ones gives 0 and sets the carry bit, `status[7]`. An accepted down pulse at 0 gives all-ones and sets the borrow bit, `status[6]`.
- R3: With `mode`=01 (one-shot), the step that wraps also sets a halt. While halted, pulses are ignored and `status[3]` reads 0. A clear or a load of the count removes the halt.
- R4: With `mode`=10 (clamped), an up pulse at count equal to the preset leaves the count unchanged. A down pulse at 0 also leaves it unchanged. A pulse in the opposite direction moves the count again.
- R5: With `mode`=11 (modulo), an up pulse at count equal to the preset gives 0 and sets carry. A down pulse at 0 loads the preset and sets borrow.
- R6: An accepted pulse whose result equals the preset sets the compare bit, `status[5]`. In modes 00 and 01 this applies to both directions. In modes 10 and 11 it applies to up pulses only.
- R7: The status layout, from bit 7 down, is: carry, borrow, compare, index, count-enable, constant 0, direction, sign.
  - Count-enable is live: `!count_inhibit` and not halted.
  - Direction is live and equals `cnt_up`.
  - `cmd_clr_status` clears bits 7..4 only. An event in the same cycle still sets its bit.
- R8: The sign is set by a borrow event and cleared by a carry event. `cmd_set_sign` forces it to 1 and `cmd_clr_sign` forces it to 0. `cmd_clr_sign` has priority over `cmd_set_sign`, and both override events.
- R9: The bits of `fa_en` are [3] carry, [2] borrow, [1] compare, [0] index.
  - With `fa_pulse`=0, `flag_a_n` is low while any enabled sticky bit is set.
  - With `fa_pulse`=1, `flag_a_n` is low for exactly the cycle after an enabled event.
- R10: `flag_b` depends on `fb_sel`: 00 gives 1, 01 gives the sign, 10 gives `cnt_up`, 11 gives 1.
- R11: Every `idx_evt` sets the index bit, `status[4]`. What it also does depends on `idx_act`: 00 does nothing more, 01 loads the preset into the count, 10 clears the count, and 11 copies the count into the snapshot.
- R12: Command rules:
  - A clear beats a load, and either one beats a count pulse in the same cycle.
  - `count_inhibit` blocks pulses.
  - A snapshot captures the count held before that edge.
  - A preset write takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pulse | input | 1 | One count pulse per cycle high |
| cnt_up | input | 1 | Direction: 1 up, 0 down |
| count_inhibit | input | 1 | Blocks counting while high |
| mode | input | 2 | Limit behaviour 00/01/10/11 |
| preset_wr | input | 1 | Write strobe for the preset |
| preset_din | input | W | New preset value |
| cmd_clear_cnt | input | 1 | Clear the count |
| cmd_load_cnt | input | 1 | Load the preset into the count |
| cmd_snap | input | 1 | Copy the count into the snapshot |
| cmd_clr_status | input | 1 | Clear the sticky status bits |
| cmd_set_sign | input | 1 | Force the sign to 1 |
| cmd_clr_sign | input | 1 | Force the sign to 0 |
| idx_act | input | 2 | Action taken on an index event |
| idx_evt | input | 1 | Index event pulse |
| fa_en | input | 4 | Event enables for `flag_a_n` |
| fa_pulse | input | 1 | 1 pulsed, 0 latched `flag_a_n` |
| fb_sel | input | 2 | Source for `flag_b` |
| count | output | W | Current count |
| snapshot | output | W | Snapshot register |
| status | output | 8 | Status byte |
| flag_a_n | output | 1 | Active-low event flag |
| flag_b | output | 1 | Sign or direction flag |

## Verification
The count is driven in each of the four modes with several pulse patterns:
- **Runs across both ends**: these show whether wrapping, halting, clamping or modulo reload is applied.
- **Direction reversals at the clamp limits**: these separate a frozen count from a halted one.
- **Runs that cross the preset going down**: these show whether compare depends on direction.
- **Same-cycle command collisions**: these expose the priority between clear, load and pulse.
- **Long random mixed stimulus**: this is checked against a behavioural model every cycle, so interactions between sign, flags and index actions are covered.

// File: rtl/poscnt_pkg.sv
package poscnt_pkg;
   typedef enum logic [1:0] {
      CM_FREE    = 2'b00,
      CM_ONESHOT = 2'b01,
      CM_CLAMP   = 2'b10,
      CM_WRAPN   = 2'b11
   } cnt_mode_e;

   typedef enum logic [1:0] {
      IX_NONE  = 2'b00,
      IX_LOAD  = 2'b01,
      IX_CLEAR = 2'b10,
      IX_SNAP  = 2'b11
   } idx_act_e;

   typedef struct packed {
      logic carry;
      logic borrow;
      logic cmp;
      logic idx;
   } evt_t;

   localparam int NUM_EVT = 4;
endpackage

// File: rtl/poscnt_step.sv
module poscnt_step
   import poscnt_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] lim,
   input  cnt_mode_e    mode,
   input  logic         up,
   input  logic         acc,
   output logic [W-1:0] nxt,
   output logic         ev_carry,
   output logic         ev_borrow,
   output logic         ev_cmp
);
   logic at_top, at_max, at_zero, dir_ok;

   assign at_top  = (cur == lim);
   assign at_max  = &cur;
   assign at_zero = (cur == '0);
   assign dir_ok  = up || (mode == CM_FREE) || (mode == CM_ONESHOT);

   always_comb begin
      nxt       = cur;
      ev_carry  = 1'b0;
      ev_borrow = 1'b0;
      if (up) begin
         if (mode == CM_CLAMP && at_top) begin
            nxt = cur;
         end else if (mode == CM_WRAPN && at_top) begin
            nxt      = '0;
            ev_carry = acc;
         end else begin
            nxt      = cur + 1'b1;
            ev_carry = acc & at_max;
         end
      end else begin
         if (mode == CM_CLAMP && at_zero) begin
            nxt = cur;
         end else if (mode == CM_WRAPN && at_zero) begin
            nxt       = lim;
            ev_borrow = acc;
         end else begin
            nxt       = cur - 1'b1;
            ev_borrow = acc & at_zero;
         end
      end
   end

   assign ev_cmp = acc && (nxt == lim) && dir_ok;
endmodule

// File: rtl/poscnt_flags.sv
module poscnt_flags
   import poscnt_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  evt_t         ev,
   input  logic         clr_stat,
   input  logic         set_sign,
   input  logic         clr_sign,
   input  logic         cen,
   input  logic         up,
   input  logic [NUM_EVT-1:0] fa_en,
   input  logic         fa_pulse,
   input  logic [1:0]   fb_sel,
   output logic [7:0]   status,
   output logic         flag_a_n,
   output logic         flag_b
);
   logic [NUM_EVT-1:0] ev_v, sticky_q, evq_q, hit_lat, hit_pls;
   logic               sign_q;

   assign ev_v = ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= '0;
         evq_q    <= '0;
         sign_q   <= 1'b0;
      end else begin
         evq_q    <= ev_v;
         sticky_q <= (clr_stat ? '0 : sticky_q) | ev_v;
         if (clr_sign)      sign_q <= 1'b0;
         else if (set_sign) sign_q <= 1'b1;
         else if (ev.borrow) sign_q <= 1'b1;
         else if (ev.carry)  sign_q <= 1'b0;
      end
   end

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_mask
      assign hit_lat[g] = fa_en[g] & sticky_q[g];
      assign hit_pls[g] = fa_en[g] & evq_q[g];
   end

   assign flag_a_n = fa_pulse ? ~|hit_pls : ~|hit_lat;
   assign status   = {sticky_q, cen, 1'b0, up, sign_q};

   always_comb begin
      case (fb_sel)
         2'b01:   flag_b = sign_q;
         2'b10:   flag_b = up;
         default: flag_b = 1'b1;
      endcase
   end
endmodule

// File: rtl/poscnt_top.sv
module poscnt_top
   import poscnt_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_pulse,
   input  logic         cnt_up,
   input  logic         count_inhibit,
   input  logic [1:0]   mode,
   input  logic         preset_wr,
   input  logic [W-1:0] preset_din,
   input  logic         cmd_clear_cnt,
   input  logic         cmd_load_cnt,
   input  logic         cmd_snap,
   input  logic         cmd_clr_status,
   input  logic         cmd_set_sign,
   input  logic         cmd_clr_sign,
   input  logic [1:0]   idx_act,
   input  logic         idx_evt,
   input  logic [3:0]   fa_en,
   input  logic         fa_pulse,
   input  logic [1:0]   fb_sel,
   output logic [W-1:0] count,
   output logic [W-1:0] snapshot,
   output logic [7:0]   status,
   output logic         flag_a_n,
   output logic         flag_b
);
   if (W < 2) begin : g_bad_width
      $error("poscnt_top: W must be at least 2");
   end

   cnt_mode_e    md;
   idx_act_e     ia;
   logic         do_clr, do_ld, do_snap, acc, halted_q, cen;
   logic [W-1:0] preset_q, nxt;
   logic         s_carry, s_borrow, s_cmp;
   evt_t         ev_all;

   assign md      = cnt_mode_e'(mode);
   assign ia      = idx_act_e'(idx_act);
   assign do_clr  = cmd_clear_cnt | (idx_evt && ia == IX_CLEAR);
   assign do_ld   = cmd_load_cnt  | (idx_evt && ia == IX_LOAD);
   assign do_snap = cmd_snap      | (idx_evt && ia == IX_SNAP);
   assign cen     = ~count_inhibit & ~halted_q;
   assign acc     = cnt_pulse & cen & ~do_clr & ~do_ld;

   poscnt_step #(.W(W)) u_step (
      .cur(count), .lim(preset_q), .mode(md), .up(cnt_up), .acc(acc),
      .nxt(nxt), .ev_carry(s_carry), .ev_borrow(s_borrow), .ev_cmp(s_cmp)
   );

   always_comb begin
      ev_all.carry  = s_carry;
      ev_all.borrow = s_borrow;
      ev_all.cmp    = s_cmp;
      ev_all.idx    = idx_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         snapshot <= '0;
         preset_q <= '0;
         halted_q <= 1'b0;
      end else begin
         if (do_snap)   snapshot <= count;
         if (preset_wr) preset_q <= preset_din;
         if (do_clr)      count <= '0;
         else if (do_ld)  count <= preset_q;
         else if (acc)    count <= nxt;
         if (do_clr || do_ld)
            halted_q <= 1'b0;
         else if (acc && md == CM_ONESHOT && (s_carry || s_borrow))
            halted_q <= 1'b1;
      end
   end

   poscnt_flags u_flags (
      .clk(clk), .rst_n(rst_n), .ev(ev_all), .clr_stat(cmd_clr_status),
      .set_sign(cmd_set_sign), .clr_sign(cmd_clr_sign), .cen(cen), .up(cnt_up),
      .fa_en(fa_en), .fa_pulse(fa_pulse), .fb_sel(fb_sel),
      .status(status), .flag_a_n(flag_a_n), .flag_b(flag_b)
   );
endmodule

// File: rtl/poscnt_chk.sv
module poscnt_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   mode,
   input logic         cnt_pulse,
   input logic         cnt_up,
   input logic         count_inhibit,
   input logic         cmd_clear_cnt,
   input logic         cmd_load_cnt,
   input logic         cmd_snap,
   input logic         cmd_clr_status,
   input logic         idx_evt,
   input logic [1:0]   idx_act,
   input logic [3:0]   fa_en,
   input logic         fa_pulse,
   input logic [W-1:0] count,
   input logic [W-1:0] snapshot,
   input logic         status_cen,
   input logic         flag_a_n,
   input logic [W-1:0] preset_q
);
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clear_cnt |=> count == '0); // R12
   AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_load_cnt && !cmd_clear_cnt && !(idx_evt && idx_act == 2'b10))
      |=> count == $past(preset_q)); // R12
   AST_SNAP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_snap |=> snapshot == $past(count)); // R12
   AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (count_inhibit && !cmd_clear_cnt && !cmd_load_cnt && !idx_evt) |=> $stable(count)); // R12
   AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && cnt_pulse && cnt_up && count == preset_q &&
       !cmd_clear_cnt && !cmd_load_cnt && !idx_evt) |=> $stable(count)); // R4
   AST_MOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && cnt_pulse && cnt_up && status_cen && count == preset_q &&
       !cmd_clear_cnt && !cmd_load_cnt && !idx_evt) |=> count == '0); // R5
   AST_INHIBIT_CEN: assert property (@(posedge clk) disable iff (!rst_n)
      count_inhibit |-> !status_cen); // R7
   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!fa_pulse && !flag_a_n && !cmd_clr_status)
      |=> (!flag_a_n || fa_pulse || fa_en != $past(fa_en))); // R9
endmodule

bind poscnt_top poscnt_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up),
   .count_inhibit(count_inhibit), .cmd_clear_cnt(cmd_clear_cnt),
   .cmd_load_cnt(cmd_load_cnt), .cmd_snap(cmd_snap), .cmd_clr_status(cmd_clr_status),
   .idx_evt(idx_evt), .idx_act(idx_act), .fa_en(fa_en), .fa_pulse(fa_pulse),
   .count(count), .snapshot(snapshot), .status_cen(status[3]),
   .flag_a_n(flag_a_n), .preset_q(preset_q)
);

// File: tb/poscnt_top_test.sv
`timescale 1ns/1ps
module poscnt_top_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cnt_pulse = 0, cnt_up = 1, count_inhibit = 0;
   logic [1:0] mode = 0;
   logic preset_wr = 0;
   logic [31:0] preset_din = 0;
   logic cmd_clear_cnt = 0, cmd_load_cnt = 0, cmd_snap = 0, cmd_clr_status = 0;
   logic cmd_set_sign = 0, cmd_clr_sign = 0;
   logic [1:0] idx_act = 0;
   logic idx_evt = 0;
   logic [3:0] fa_en = 0;
   logic fa_pulse = 0;
   logic [1:0] fb_sel = 0;
   logic [31:0] count, snapshot;
   logic [7:0] status;
   logic flag_a_n, flag_b;

   int checks = 0, errors = 0;
   string cur_req = "R1";
   bit done = 0;

   always #2.5 clk = ~clk;

   poscnt_top #(.W(32)) uut (
      .clk(clk), .rst_n(rst_n), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up),
      .count_inhibit(count_inhibit), .mode(mode), .preset_wr(preset_wr),
      .preset_din(preset_din), .cmd_clear_cnt(cmd_clear_cnt), .cmd_load_cnt(cmd_load_cnt),
      .cmd_snap(cmd_snap), .cmd_clr_status(cmd_clr_status), .cmd_set_sign(cmd_set_sign),
      .cmd_clr_sign(cmd_clr_sign), .idx_act(idx_act), .idx_evt(idx_evt), .fa_en(fa_en),
      .fa_pulse(fa_pulse), .fb_sel(fb_sel), .count(count), .snapshot(snapshot),
      .status(status), .flag_a_n(flag_a_n), .flag_b(flag_b)
   );

   // behavioural reference state
   longint m_cnt, m_pre, m_snap;
   bit m_c, m_b, m_cmp, m_idx, m_halt, m_sign;
   bit m_ec, m_eb, m_ecmp, m_eidx;
   localparam longint SPAN = 64'h1_0000_0000;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_snap = 0;
         {m_c, m_b, m_cmp, m_idx, m_halt, m_sign} = '0;
         {m_ec, m_eb, m_ecmp, m_eidx} = '0;
      end else begin
         bit clr, ld, acc, ec, eb, ecmp;
         longint n;
         clr = cmd_clear_cnt || (idx_evt && idx_act == 2);
         ld  = cmd_load_cnt  || (idx_evt && idx_act == 1);
         acc = cnt_pulse && !count_inhibit && !m_halt && !clr && !ld;
         ec = 0; eb = 0; ecmp = 0; n = m_cnt;
         if (acc) begin
            if (cnt_up) begin
               if (mode == 2 && m_cnt == m_pre) n = m_cnt;
               else if (mode == 3 && m_cnt == m_pre) begin n = 0; ec = 1; end
               else begin n = (m_cnt + 1) % SPAN; ec = (n == 0); end
            end else begin
               if (mode == 2 && m_cnt == 0) n = 0;
               else if (mode == 3 && m_cnt == 0) begin n = m_pre; eb = 1; end
               else begin n = (m_cnt + SPAN - 1) % SPAN; eb = (m_cnt == 0); end
            end
            ecmp = (n == m_pre) && (cnt_up || mode < 2);
         end
         if (cmd_snap || (idx_evt && idx_act == 3)) m_snap = m_cnt;
         if (clr) m_cnt = 0; else if (ld) m_cnt = m_pre; else m_cnt = n;
         if (clr || ld) m_halt = 0;
         else if (acc && mode == 1 && (ec || eb)) m_halt = 1;
         if (preset_wr) m_pre = longint'(preset_din);
         if (cmd_clr_status) {m_c, m_b, m_cmp, m_idx} = '0;
         m_c |= ec; m_b |= eb; m_cmp |= ecmp; m_idx |= idx_evt;
         if (cmd_clr_sign) m_sign = 0;
         else if (cmd_set_sign) m_sign = 1;
         else if (eb) m_sign = 1;
         else if (ec) m_sign = 0;
         m_ec = ec; m_eb = eb; m_ecmp = ecmp; m_eidx = idx_evt;
      end
   end

   task automatic chk(string what, longint got, longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   task automatic compare();
      bit e_cen, lat, pls, e_fb;
      logic [7:0] e_st;
      e_cen = !count_inhibit && !m_halt;
      e_st = {m_c, m_b, m_cmp, m_idx, e_cen, 1'b0, cnt_up, m_sign};
      lat = |({m_c, m_b, m_cmp, m_idx} & fa_en);
      pls = |({m_ec, m_eb, m_ecmp, m_eidx} & fa_en);
      e_fb = (fb_sel == 1) ? m_sign : (fb_sel == 2) ? cnt_up : 1'b1;
      chk("count", count, m_cnt);
      chk("snapshot", snapshot, m_snap);
      chk("status", status, e_st);
      chk("flag_a_n", flag_a_n, !(fa_pulse ? pls : lat));
      chk("flag_b", flag_b, e_fb);
   endtask

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
      end
   endtask

   task automatic pulses(int n, bit up);
      for (int i = 0; i < n; i++) begin
         cnt_pulse = 1; cnt_up = up; cyc(1);
      end
      cnt_pulse = 0; cyc(1);
   endtask

   task automatic set_preset(logic [31:0] v);
      preset_wr = 1; preset_din = v; cyc(1); preset_wr = 0;
   endtask
   task automatic clear_cnt(); cmd_clear_cnt = 1; cyc(1); cmd_clear_cnt = 0; endtask
   task automatic load_cnt();  cmd_load_cnt = 1;  cyc(1); cmd_load_cnt = 0;  endtask
   task automatic clr_stat();  cmd_clr_status = 1; cyc(1); cmd_clr_status = 0; endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state
      cur_req = "R1";
      cyc(3);
      rst_n = 1;
      cyc(2);

      // R2 free wrap both ends
      cur_req = "R2";
      fa_en = 4'b1100;
      set_preset(32'hFFFF_FFFE); load_cnt();
      pulses(3, 1);
      pulses(3, 0);
      clr_stat();

      // R7 inhibit and status clear with simultaneous event
      cur_req = "R7";
      count_inhibit = 1; pulses(3, 1); count_inhibit = 0;
      set_preset(32'h0); load_cnt();
      cmd_clr_status = 1; cnt_pulse = 1; cnt_up = 0; cyc(1);
      cmd_clr_status = 0; cnt_pulse = 0; cyc(2);

      // R3 one-shot halt and restart
      cur_req = "R3";
      mode = 2'b01; clr_stat();
      set_preset(32'hFFFF_FFFF); load_cnt();
      pulses(4, 1);
      load_cnt(); pulses(2, 0);
      clear_cnt(); pulses(2, 0);
      clear_cnt(); pulses(2, 1);

      // R4 clamped, R6 compare direction
      cur_req = "R4";
      mode = 2'b10; fa_en = 4'b0010; clr_stat();
      set_preset(32'd3); clear_cnt();
      pulses(6, 1); pulses(5, 0); pulses(1, 1);
      cur_req = "R6";
      clr_stat(); set_preset(32'd1); set_preset(32'd1);
      preset_din = 0; load_cnt(); set_preset(32'd2); pulses(1, 1);
      set_preset(32'd1); clr_stat(); pulses(1, 0);

      // R5 modulo
      cur_req = "R5";
      mode = 2'b11; fa_en = 4'b1110; clr_stat();
      set_preset(32'd3); clear_cnt();
      pulses(9, 1); pulses(9, 0);

      // R9 pulsed versus latched flag
      cur_req = "R9";
      fa_pulse = 1; clr_stat(); pulses(5, 1);
      fa_pulse = 0; fa_en = 4'b1000; cyc(2); clr_stat(); cyc(1);

      // R8 sign commands
      cur_req = "R8";
      fb_sel = 2'b01;
      cmd_set_sign = 1; cyc(1); cmd_set_sign = 0; cyc(1);
      cmd_clr_sign = 1; cmd_set_sign = 1; cyc(1); cmd_clr_sign = 0; cmd_set_sign = 0; cyc(1);
      mode = 2'b00; clear_cnt(); pulses(1, 0); pulses(1, 1);
      cmd_clr_sign = 1; cnt_pulse = 1; cnt_up = 0; cyc(1);
      cmd_clr_sign = 0; cnt_pulse = 0; cyc(1);

      // R10 flag_b sources
      cur_req = "R10";
      for (int s = 0; s < 4; s++) begin
         fb_sel = 2'(s); cnt_up = 0; cyc(1); cnt_up = 1; cyc(1);
      end

      // R11 index actions
      cur_req = "R11";
      fa_en = 4'b0001; set_preset(32'd77); clear_cnt(); pulses(2, 1);
      for (int a = 0; a < 4; a++) begin
         idx_act = 2'(a); idx_evt = 1; cyc(1); idx_evt = 0; cyc(1);
         pulses(1, 1);
      end
      clr_stat();

      // R12 collisions and snapshot
      cur_req = "R12";
      cmd_clear_cnt = 1; cmd_load_cnt = 1; cnt_pulse = 1; cyc(1);
      cmd_clear_cnt = 0; cnt_pulse = 1; cyc(1);
      cmd_load_cnt = 0; cnt_pulse = 0; cyc(1);
      preset_wr = 1; preset_din = 32'd500; cmd_load_cnt = 1; cyc(1);
      preset_wr = 0; cyc(1); cmd_load_cnt = 0;
      cmd_snap = 1; cnt_pulse = 1; cyc(1); cmd_snap = 0; cnt_pulse = 0; cyc(1);

      // mixed random traffic across all functions
      cur_req = "R12";
      for (int i = 0; i < 3000; i++) begin
         cnt_pulse      = ($urandom % 3) != 0;
         cnt_up         = ($urandom % 4) != 0 ? cnt_up : ~cnt_up;
         count_inhibit  = ($urandom % 16) == 0;
         if (($urandom % 200) == 0) mode = 2'($urandom);
         preset_wr      = ($urandom % 40) == 0;
         preset_din     = ($urandom % 2) ? ($urandom % 12) : 32'hFFFF_FFF8 + ($urandom % 8);
         cmd_clear_cnt  = ($urandom % 60) == 0;
         cmd_load_cnt   = ($urandom % 30) == 0;
         cmd_snap       = ($urandom % 10) == 0;
         cmd_clr_status = ($urandom % 12) == 0;
         cmd_set_sign   = ($urandom % 50) == 0;
         cmd_clr_sign   = ($urandom % 50) == 0;
         idx_evt        = ($urandom % 25) == 0;
         idx_act        = 2'($urandom);
         if (($urandom % 50) == 0) fa_en = 4'($urandom);
         if (($urandom % 80) == 0) fa_pulse = ~fa_pulse;
         if (($urandom % 60) == 0) fb_sel = 2'($urandom);
         cyc(1);
      end
      {cnt_pulse, preset_wr, cmd_clear_cnt, cmd_load_cnt, cmd_snap} = '0;
      {cmd_clr_status, cmd_set_sign, cmd_clr_sign, idx_evt} = '0;
      cyc(2);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule